// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation buffer after a lookup misses. Given a 32-bit virtual address, it reads the root of a two-level page table from a table-base input and fetches one 4-byte entry per level through a single-word memory read port. The tables live in untranslated physical memory. The walk ends in one of two ways. It can return a physical page number with read, write and execute permission bits, ready to be written into the translation buffer and passed on to the protection check. Otherwise it returns a page-fault indication.

The upper ten bits of the virtual address index the first-level table and the next ten bits index the second-level table. The low twelve bits are the byte offset inside a 4 KiB page. A leaf entry met at the first level maps a 4 MiB large page, and the walk stops there. A leaf met at the second level maps a 4 KiB page. Only one walk runs at a time. While `busy_o` is high, new miss requests are held off.

Top module: `pt_walker`

## Requirements
- R1: A miss is accepted on a rising edge where `miss_valid_i` is high and `busy_o` is low. `busy_o` is high from the next cycle up to and including the cycle in which `done_o` is high. It is low in the cycle after `done_o`.
- R2: The first read goes to physical address root_ppn*4096 + vaddr[31:22]*4.
- R3: When the first entry is a table pointer, the second read goes to pointer_ppn*4096 + vaddr[21:12]*4.
- R4: The entry layout is: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bits 31:10 page number. A valid entry with all three permission bits clear is a pointer to the next table. `perm_o` reports {execute, write, read}.
- R5: An entry with bit 0 clear faults the walk at either level and no further read is made. On any fault, `ppn_o`, `perm_o` and `large_o` are zero.
- R6: A first-level leaf whose page-number bits 9:0 are zero completes after exactly one read. It returns `large_o`=1, the entry's page-number bits 21:10 joined to vaddr[21:12], and the entry's permissions.
- R7: A first-level leaf whose page-number bits 9:0 are not all zero faults after one read.
- R8: A second-level leaf returns the entry's full page number, its permissions and `large_o`=0.
- R9: A second-level entry that is a pointer faults, because no third level exists.
- R10: Once `mem_req_valid_o` is raised, it and `mem_req_addr_o` stay unchanged until a cycle in which `mem_req_ready_i` is high.
- R11: The root page number and the virtual address are taken when the miss is accepted. Later changes on those inputs do not affect the walk in progress.
- R12: `done_o` is high for exactly one cycle per walk. This cycle follows the response of the last read, and the result outputs are valid in it.
- R13: At most one read is outstanding. No read is requested while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_ppn_i | input | 22 | Page number of the first-level table |
| miss_valid_i | input | 1 | Miss request |
| miss_vaddr_i | input | 32 | Virtual address that missed |
| busy_o | output | 1 | Walk in progress; new requests stall |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_addr_o | output | 34 | Physical byte address of the entry |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry word returned |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Walk ended in a page fault |
| ppn_o | output | 22 | Translated physical page number |
| perm_o | output | 3 | {execute, write, read} |
| large_o | output | 1 | Result maps a 4 MiB page |

## Verification
Two functions can meet in the same cycle: the completion strobe of one walk and a new miss request that has been waiting for it. The bench raises a second miss right after the first is accepted and holds it high through the whole walk. It then checks three things. The number of reads issued before `done_o` equals the count the first walk needs. `busy_o` is still high in the `done_o` cycle. The held request starts only after `busy_o` falls, and its result is correct. The wider sweep also changes the root and address inputs while each walk runs, and it compares every read address and result with values computed from the index arithmetic.

// File: rtl/ptw_pkg.sv
// Shared constants and types for the two-level page table walker.
// Assumes the level index width plus two byte-select bits equals the
// page offset width, so an entry address is a plain concatenation.
package ptw_pkg;
    localparam int VA_W    = 32;
    localparam int IDX_W   = 10;
    localparam int OFF_W   = 12;
    localparam int PPN_W   = 22;
    localparam int PTE_W   = 32;
    localparam int PERM_W  = 3;
    localparam int PA_W    = PPN_W + OFF_W;
    localparam int VPN_W   = 2 * IDX_W;
    localparam int RSVD_W  = PTE_W - PPN_W - PERM_W - 1;

    // Walk sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;

    // Meaning of a fetched entry at the current level
    typedef enum logic [1:0] {
        KIND_FAULT,
        KIND_NEXT,
        KIND_LEAF
    } pte_kind_e;
endpackage

// File: rtl/ptw_entry_addr.sv
// Forms the physical byte address of a table entry from the table page
// number and the index field selected by the current level.
// Assumes IDX_W + 2 == OFF_W (4-byte entries fill one page exactly).
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [PPN_W-1:0] base_ppn_i,
    input  logic [VPN_W-1:0] vpn_i,
    input  logic             level_i,
    output logic [PA_W-1:0]  addr_o
);
    logic [IDX_W-1:0] idx;

    // Pick the upper index on the first level, the lower one on the second
    always_comb begin
        idx    = level_i ? vpn_i[IDX_W-1:0] : vpn_i[VPN_W-1:IDX_W];
        addr_o = {base_ppn_i, idx, 2'b00};
    end
endmodule

// File: rtl/ptw_entry_decode.sv
// Classifies a fetched entry for the current level and forms the leaf
// page number. Assumes a valid entry without permissions is a pointer,
// and that a second-level pointer is illegal.
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]  pte_i,
    input  logic              level_i,
    input  logic [IDX_W-1:0]  l2_idx_i,
    output pte_kind_e         kind_o,
    output logic [PPN_W-1:0]  leaf_ppn_o,
    output logic [PERM_W-1:0] perm_o
);
    logic             valid;
    logic [PPN_W-1:0] pte_ppn;
    logic [PPN_W-1:0] large_ppn;
    logic             misaligned;
    logic [RSVD_W-1:0] unused_pte_bits;

    assign valid           = pte_i[0];
    assign perm_o          = pte_i[PERM_W:1];
    assign unused_pte_bits = pte_i[PTE_W-PPN_W-1:PERM_W+1];
    assign pte_ppn         = pte_i[PTE_W-1:PTE_W-PPN_W];
    assign misaligned      = |pte_ppn[IDX_W-1:0];

    // Large page number: low bits come from the second-level index
    for (genvar b = 0; b < PPN_W; b++) begin : g_large
        if (b < IDX_W) begin : g_low
            assign large_ppn[b] = l2_idx_i[b];
        end else begin : g_high
            assign large_ppn[b] = pte_ppn[b];
        end
    end

    // Decide fault, pointer or leaf for this level
    always_comb begin
        if (!valid) begin
            kind_o = KIND_FAULT;
        end else if (perm_o == '0) begin
            kind_o = level_i ? KIND_FAULT : KIND_NEXT;
        end else if (!level_i && misaligned) begin
            kind_o = KIND_FAULT;
        end else begin
            kind_o = KIND_LEAF;
        end
        leaf_ppn_o = level_i ? pte_ppn : large_ppn;
    end
endmodule

// File: rtl/ptw_ctrl.sv
// Sequences one walk: first-level read, optional second-level read, and
// one result cycle. Assumes one outstanding read and that a response
// arrives only while a read is pending.
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      miss_valid_i,
    input  logic      mem_req_ready_i,
    input  logic      mem_rsp_valid_i,
    input  pte_kind_e kind_i,
    output logic      accept_o,
    output logic      load_ptr_o,
    output logic      finish_o,
    output logic      level_o,
    output logic      mem_req_valid_o,
    output logic      busy_o,
    output logic      done_o
);
    walk_state_e state_q, state_d;

    // Next-state and strobe logic
    always_comb begin
        state_d         = state_q;
        accept_o        = 1'b0;
        load_ptr_o      = 1'b0;
        finish_o        = 1'b0;
        mem_req_valid_o = 1'b0;
        level_o         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (miss_valid_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_L1_REQ;
                end
            end
            ST_L1_REQ: begin
                mem_req_valid_o = 1'b1;
                if (mem_req_ready_i) state_d = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (kind_i == KIND_NEXT) begin
                        load_ptr_o = 1'b1;
                        state_d    = ST_L2_REQ;
                    end else begin
                        finish_o = 1'b1;
                        state_d  = ST_DONE;
                    end
                end
            end
            ST_L2_REQ: begin
                level_o         = 1'b1;
                mem_req_valid_o = 1'b1;
                if (mem_req_ready_i) state_d = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                level_o = 1'b1;
                if (mem_rsp_valid_i) begin
                    finish_o = 1'b1;
                    state_d  = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. Captures the miss address and root page
// number on acceptance, reads up to two entries, and presents a
// registered result with a one-cycle done strobe. Assumes the tables sit
// in untranslated physical memory.
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PPN_W-1:0]  root_ppn_i,
    input  logic              miss_valid_i,
    input  logic [VA_W-1:0]   miss_vaddr_i,
    output logic              busy_o,
    output logic              mem_req_valid_o,
    output logic [PA_W-1:0]   mem_req_addr_o,
    input  logic              mem_req_ready_i,
    input  logic              mem_rsp_valid_i,
    input  logic [PTE_W-1:0]  mem_rsp_data_i,
    output logic              done_o,
    output logic              fault_o,
    output logic [PPN_W-1:0]  ppn_o,
    output logic [PERM_W-1:0] perm_o,
    output logic              large_o
);
    logic [VPN_W-1:0]  vpn_q;
    logic [PPN_W-1:0]  base_q;
    logic              accept, load_ptr, finish, level;
    pte_kind_e         kind;
    logic [PPN_W-1:0]  leaf_ppn;
    logic [PERM_W-1:0] leaf_perm;
    logic              fault_q, large_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [PERM_W-1:0] perm_q;
    logic [OFF_W-1:0]  unused_offset_bits;

    assign unused_offset_bits = miss_vaddr_i[OFF_W-1:0];

    ptw_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .miss_valid_i    (miss_valid_i),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .kind_i          (kind),
        .accept_o        (accept),
        .load_ptr_o      (load_ptr),
        .finish_o        (finish),
        .level_o         (level),
        .mem_req_valid_o (mem_req_valid_o),
        .busy_o          (busy_o),
        .done_o          (done_o)
    );

    ptw_entry_addr u_addr (
        .base_ppn_i (base_q),
        .vpn_i      (vpn_q),
        .level_i    (level),
        .addr_o     (mem_req_addr_o)
    );

    ptw_entry_decode u_dec (
        .pte_i      (mem_rsp_data_i),
        .level_i    (level),
        .l2_idx_i   (vpn_q[IDX_W-1:0]),
        .kind_o     (kind),
        .leaf_ppn_o (leaf_ppn),
        .perm_o     (leaf_perm)
    );

    // Capture the page number and root on acceptance, then the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            base_q <= '0;
        end else if (accept) begin
            vpn_q  <= miss_vaddr_i[VA_W-1:OFF_W];
            base_q <= root_ppn_i;
        end else if (load_ptr) begin
            base_q <= mem_rsp_data_i[PTE_W-1:PTE_W-PPN_W];
        end
    end

    // Register the walk outcome; faults clear the translation fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
            ppn_q   <= '0;
            perm_q  <= '0;
            large_q <= 1'b0;
        end else if (finish) begin
            if (kind == KIND_FAULT) begin
                fault_q <= 1'b1;
                ppn_q   <= '0;
                perm_q  <= '0;
                large_q <= 1'b0;
            end else begin
                fault_q <= 1'b0;
                ppn_q   <= leaf_ppn;
                perm_q  <= leaf_perm;
                large_q <= !level;
            end
        end
    end

    assign fault_o = fault_q;
    assign ppn_o   = ppn_q;
    assign perm_o  = perm_q;
    assign large_o = large_q;
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and result checks for the page table walker, bound to the top.
module pt_walker_chk
    import ptw_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid_i,
    input logic [IDX_W-1:0]  va_l2_idx_i,
    input logic              busy_o,
    input logic              mem_req_valid_o,
    input logic [PA_W-1:0]   mem_req_addr_o,
    input logic              mem_req_ready_i,
    input logic              mem_rsp_valid_i,
    input logic              done_o,
    input logic              fault_o,
    input logic [PPN_W-1:0]  ppn_o,
    input logic [PERM_W-1:0] perm_o,
    input logic              large_o
);
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       pending;

    // Track the second-level index of the accepted miss
    always_ff @(posedge clk) begin
        if (!rst_n)                       idx_q <= '0;
        else if (miss_valid_i && !busy_o) idx_q <= va_l2_idx_i;
    end

    // Count reads issued but not yet answered
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else pending <= pending
                      + {1'b0, (mem_req_valid_o && mem_req_ready_i)}
                      - {1'b0, mem_rsp_valid_i};
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_busy_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_valid_o);

    assert_single_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> pending == 2'd0);

    assert_fault_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && fault_o |-> ppn_o == '0 && perm_o == '0 && !large_o);

    assert_large_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && large_o |-> ppn_o[IDX_W-1:0] == idx_q);

    assert_leaf_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !fault_o |-> perm_o != '0);
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .miss_valid_i    (miss_valid_i),
    .va_l2_idx_i     (miss_vaddr_i[21:12]),
    .busy_o          (busy_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .done_o          (done_o),
    .fault_o         (fault_o),
    .ppn_o           (ppn_o),
    .perm_o          (perm_o),
    .large_o         (large_o)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
    localparam logic [21:0] ROOT = 22'h00055;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] root_ppn_i = ROOT;
    logic        miss_valid_i = 1'b0;
    logic [31:0] miss_vaddr_i = '0;
    logic        busy_o, mem_req_valid_o, mem_req_ready_i, mem_rsp_valid_i;
    logic [33:0] mem_req_addr_o;
    logic [31:0] mem_rsp_data_i;
    logic        done_o, fault_o, large_o;
    logic [21:0] ppn_o;
    logic [2:0]  perm_o;

    int n_tests = 0;
    int n_fail  = 0;
    int rd_total = 0;
    logic [33:0] rd_log [0:7];

    always #2.5 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .root_ppn_i(root_ppn_i),
        .miss_valid_i(miss_valid_i), .miss_vaddr_i(miss_vaddr_i),
        .busy_o(busy_o), .mem_req_valid_o(mem_req_valid_o),
        .mem_req_addr_o(mem_req_addr_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .done_o(done_o), .fault_o(fault_o), .ppn_o(ppn_o),
        .perm_o(perm_o), .large_o(large_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Table contents computed from the entry address
    function automatic logic [31:0] pte_word(input logic [33:0] a);
        logic [21:0] pg;
        int          ix;
        pg = a[33:12];
        ix = int'(a[11:2]);
        if (pg == ROOT) begin
            case (ix % 4)
                0: return {22'(ix), 6'b0, 4'b1110};
                1: return {22'(32'h100 + ix), 6'b0, 4'b0001};
                2: return {12'(ix), 10'b0, 6'b0, 3'(((ix >> 2) % 7) + 1), 1'b1};
                default: return {12'(ix), 10'(ix | 1), 6'b0, 4'b1111};
            endcase
        end else if (pg >= 22'h100 && pg < 22'h500) begin
            case (ix % 3)
                0: return {pg ^ 22'(ix), 6'b0, 4'b1110};
                1: return {pg[11:0], 10'(ix), 6'b0, 3'((ix % 7) + 1), 1'b1};
                default: return {22'(ix), 6'b0, 4'b0001};
            endcase
        end
        return 32'h0;
    endfunction

    // Memory responder: variable ready and latency, one read at a time
    initial begin
        int cyc = 0;
        int pend = 0;
        logic [33:0] pa = '0;
        mem_req_ready_i = 1'b0;
        mem_rsp_valid_i = 1'b0;
        mem_rsp_data_i  = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid_i = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    mem_rsp_valid_i = 1'b1;
                    mem_rsp_data_i  = pte_word(pa);
                end
            end
            mem_req_ready_i = (cyc % 3 != 1);
            if (mem_req_valid_o && mem_req_ready_i && pend == 0 && rst_n) begin
                pa = mem_req_addr_o;
                rd_log[rd_total % 8] = pa;
                rd_total++;
                pend = 1 + (cyc % 3);
            end
        end
    end

    // Expected outcome for first index i and second index j
    task automatic expect_walk(input int i, input int j, output bit f,
                               output logic [21:0] p, output logic [2:0] pm,
                               output bit lg, output int nr, output logic [33:0] a1);
        logic [21:0] tp;
        tp = 22'(32'h100 + i);
        f = 1'b1; p = '0; pm = '0; lg = 1'b0; nr = 1; a1 = '0;
        case (i % 4)
            1: begin
                nr = 2;
                a1 = {tp, 10'(j), 2'b00};
                if (j % 3 == 1) begin
                    f = 1'b0; p = {tp[11:0], 10'(j)}; pm = 3'((j % 7) + 1);
                end
            end
            2: begin
                f = 1'b0; lg = 1'b1; p = {12'(i), 10'(j)};
                pm = 3'(((i >> 2) % 7) + 1);
            end
            default: ;
        endcase
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (!done_o && t < 60) begin
            @(negedge clk);
            t++;
        end
        chk(done_o, "R12", {tag, " done seen"}, 64'(done_o), 64'd1);
    endtask

    task automatic check_result(input int i, input int j, input int start, input string tag);
        bit f, lg;
        logic [21:0] p;
        logic [2:0] pm;
        int nr;
        logic [33:0] a1;
        expect_walk(i, j, f, p, pm, lg, nr, a1);
        chk(busy_o, "R1", {tag, " busy at done"}, 64'(busy_o), 64'd1);
        chk(rd_total - start == nr, (nr == 1) ? "R6" : "R3", {tag, " read count"},
            64'(rd_total - start), 64'(nr));
        chk(rd_log[start % 8] == {ROOT, 10'(i), 2'b00}, "R2", {tag, " first address"},
            64'(rd_log[start % 8]), 64'({ROOT, 10'(i), 2'b00}));
        if (nr == 2)
            chk(rd_log[(start + 1) % 8] == a1, "R3", {tag, " second address"},
                64'(rd_log[(start + 1) % 8]), 64'(a1));
        chk(fault_o == f, (i % 4 == 3) ? "R7" : (i % 4 == 0) ? "R5" : "R9",
            {tag, " fault"}, 64'(fault_o), 64'(f));
        chk(ppn_o == p, lg ? "R6" : "R8", {tag, " ppn"}, 64'(ppn_o), 64'(p));
        chk(perm_o == pm, "R4", {tag, " perm"}, 64'(perm_o), 64'(pm));
        chk(large_o == lg, "R6", {tag, " large"}, 64'(large_o), 64'(lg));
    endtask

    // One isolated walk; root and address inputs change after acceptance (R11)
    task automatic walk(input int i, input int j);
        int start;
        start = rd_total;
        @(negedge clk);
        miss_valid_i = 1'b1;
        miss_vaddr_i = {10'(i), 10'(j), 12'hABC};
        root_ppn_i   = ROOT;
        @(negedge clk);
        miss_valid_i = 1'b0;
        miss_vaddr_i = ~miss_vaddr_i;
        root_ppn_i   = 22'h2A000 ^ 22'(i);
        wait_done("walk");
        check_result(i, j, start, "R11 walk");
        @(negedge clk);
        chk(!busy_o, "R1", "busy after done", 64'(busy_o), 64'd0);
        chk(!done_o, "R12", "done single cycle", 64'(done_o), 64'd0);
    endtask

    // A second miss held high across the first walk's completion
    task automatic pair(input int ia, input int ja, input int ib, input int jb);
        int start;
        start = rd_total;
        @(negedge clk);
        miss_valid_i = 1'b1;
        miss_vaddr_i = {10'(ia), 10'(ja), 12'h001};
        root_ppn_i   = ROOT;
        @(negedge clk);
        miss_vaddr_i = {10'(ib), 10'(jb), 12'h002};
        wait_done("pair A");
        check_result(ia, ja, start, "R1 pair A");
        @(negedge clk);
        chk(!busy_o && !mem_req_valid_o, "R1", "idle gap before held miss",
            64'({busy_o, mem_req_valid_o}), 64'd0);
        start = rd_total;
        @(negedge clk);
        miss_valid_i = 1'b0;
        chk(busy_o, "R1", "held miss accepted", 64'(busy_o), 64'd1);
        wait_done("pair B");
        check_result(ib, jb, start, "R1 pair B");
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!busy_o && !done_o && !mem_req_valid_o, "R13", "reset idle",
            64'({busy_o, done_o, mem_req_valid_o}), 64'd0);
        chk(!fault_o && ppn_o == '0 && perm_o == '0 && !large_o, "R5", "reset result",
            64'({fault_o, ppn_o, perm_o, large_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Full sweep of first-level indices, second index spread arithmetically
        for (int i = 0; i < 1024; i++) walk(i, (i * 37 + 5) % 1024);
        // Every second-level category under a few pointer entries
        for (int k = 0; k < 9; k++) walk(4 * k + 1, 1020 + (k % 3) - 3 * (k / 3));
        // Corner indices: all-zero and all-ones fields
        walk(1, 0); walk(1021, 1023); walk(1022, 1023); walk(1023, 0);
        // Completion and a waiting miss in the same cycle
        pair(2, 7, 5, 4);
        pair(0, 0, 9, 1);
        pair(13, 16, 6, 1023);
        pair(3, 3, 1, 2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule